// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a small chip. It takes the four test inputs (clock, mode select, serial data in and an active-low asynchronous reset) and drives one serial data output with its pad enable. Inside it sits the sixteen-state controller that follows the mode-select line on rising test-clock edges. It also holds a four-bit instruction register and its decoder, a single-bit bypass stage and a thirty-two-bit identification register.

The boundary cells sit outside the block. The block steers them with level strobes for capture, shift and update, and with two mode lines: one for external-test drive and one for internal test. It takes the chain's serial output back on `bsr_so`. Board test software loads an instruction through the IR path and then moves data through whichever data register that instruction selects.

The identification word is built from three parameters: a 4-bit version, a 16-bit part number and an 11-bit maker code. A constant 1 fills the lowest bit.

Top module: `scan_port`

## Requirements
- R1: While `trst_n` is low, with no test-clock edge needed, the controller sits in Test-Logic-Reset, `instr` reads 0100 (IDCODE), `tdo_en` is low and all boundary strobes are low.
- R2: The controller follows the standard sixteen-state graph on rising `tck`, and five consecutive cycles with `tms` high reach Test-Logic-Reset from any state.
- R3: In Capture-IR the instruction shift stage loads 0001. In Shift-IR it shifts `tdi` in at bit 3, and bit 0 appears first on `tdo`.
- R4: `instr` changes only on a falling `tck` edge, and only while the controller is in Update-IR (where it takes the shifted value) or in Test-Logic-Reset (where it reloads 0100).
- R5: Under IDCODE (0100), Capture-DR loads {VERSION[3:0], PART[15:0], MAKER[10:0], 1'b1}, and Shift-DR moves that word out on `tdo` least significant bit first.
- R6: BYPASS (1111), USER1 (0101) and every unlisted code select a one-bit path. That path captures 0, so `tdo` shows 0 first and then `tdi` delayed by one shift cycle.
- R7: CLAMP (0011) selects the one-bit bypass path and holds `bsr_extest` high, and it keeps the capture, shift and update strobes low.
- R8: EXTEST (0000), SAMPLE (0001) and INTEST (0010) select the boundary chain. `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and in Shift-DR `tdo` carries `bsr_so`.
- R9: `bsr_extest` is high exactly for EXTEST and CLAMP, and `bsr_intest` is high exactly for INTEST.
- R10: `tdo` and `tdo_en` change on falling `tck`, and `tdo_en` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Pad enable for tdo |
| instr | output | 4 | Active instruction |
| bsr_so | input | 1 | Serial output of the boundary chain |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_extest | output | 1 | Boundary outputs driven from update latches |
| bsr_intest | output | 1 | Boundary cells in internal-test mode |

## Verification
The bench builds the block with VERSION 3, PART 0x7A5C and MAKER 0x2B1. These values give an identification word with both ones and zeros in every field, so a swapped field, a wrong shift direction or a missing fixed bit changes the bits that come out serially. The bench loads every defined instruction code and one unlisted code. It walks both pause loops and checks the five-ones return from inside a data scan. It also pulls the reset low between clock edges to show that the reset does not wait for the clock.

// File: rtl/scan_port.sv
module scan_port #(
  parameter logic [3:0]  VERSION = 4'h3,
  parameter logic [15:0] PART    = 16'h7a5c,
  parameter logic [10:0] MAKER   = 11'h2b1
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_en,
  output logic [3:0] instr,
  input  logic       bsr_so,
  output logic       bsr_capture,
  output logic       bsr_shift,
  output logic       bsr_update,
  output logic       bsr_extest,
  output logic       bsr_intest
);
  localparam int IR_W = 4;
  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART, MAKER, 1'b1};
  localparam logic [IR_W-1:0] I_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] I_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] I_INTEST = 4'b0010;
  localparam logic [IR_W-1:0] I_CLAMP  = 4'b0011;
  localparam logic [IR_W-1:0] I_IDCODE = 4'b0100;
  localparam logic [IR_W-1:0] IR_CAPT  = 4'b0001;

  typedef enum logic [3:0] {
    S_RESET  = 4'd0,  S_IDLE   = 4'd1,
    S_DR_SEL = 4'd2,  S_DR_CAP = 4'd3,  S_DR_SH  = 4'd4,  S_DR_EX1 = 4'd5,
    S_DR_PAU = 4'd6,  S_DR_EX2 = 4'd7,  S_DR_UPD = 4'd8,
    S_IR_SEL = 4'd9,  S_IR_CAP = 4'd10, S_IR_SH  = 4'd11, S_IR_EX1 = 4'd12,
    S_IR_PAU = 4'd13, S_IR_EX2 = 4'd14, S_IR_UPD = 4'd15
  } tap_st_t;

  tap_st_t st, st_nx;
  logic [IR_W-1:0] ir_sr;
  logic [ID_W-1:0] id_sr;
  logic byp;
  logic sel_id, sel_bsr, dr_bit;

  always_comb begin
    case (st)
      S_RESET:  st_nx = tms ? S_RESET  : S_IDLE;
      S_IDLE:   st_nx = tms ? S_DR_SEL : S_IDLE;
      S_DR_SEL: st_nx = tms ? S_IR_SEL : S_DR_CAP;
      S_DR_CAP: st_nx = tms ? S_DR_EX1 : S_DR_SH;
      S_DR_SH:  st_nx = tms ? S_DR_EX1 : S_DR_SH;
      S_DR_EX1: st_nx = tms ? S_DR_UPD : S_DR_PAU;
      S_DR_PAU: st_nx = tms ? S_DR_EX2 : S_DR_PAU;
      S_DR_EX2: st_nx = tms ? S_DR_UPD : S_DR_SH;
      S_DR_UPD: st_nx = tms ? S_DR_SEL : S_IDLE;
      S_IR_SEL: st_nx = tms ? S_RESET  : S_IR_CAP;
      S_IR_CAP: st_nx = tms ? S_IR_EX1 : S_IR_SH;
      S_IR_SH:  st_nx = tms ? S_IR_EX1 : S_IR_SH;
      S_IR_EX1: st_nx = tms ? S_IR_UPD : S_IR_PAU;
      S_IR_PAU: st_nx = tms ? S_IR_EX2 : S_IR_PAU;
      S_IR_EX2: st_nx = tms ? S_IR_UPD : S_IR_SH;
      S_IR_UPD: st_nx = tms ? S_DR_SEL : S_IDLE;
      default:  st_nx = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= S_RESET;
    else         st <= st_nx;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
      id_sr <= '0;
      byp   <= 1'b0;
    end else begin
      if (st == S_IR_CAP)     ir_sr <= IR_CAPT;
      else if (st == S_IR_SH) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (st == S_DR_CAP) begin
        id_sr <= ID_WORD;
        byp   <= 1'b0;
      end else if (st == S_DR_SH) begin
        id_sr <= {tdi, id_sr[ID_W-1:1]};
        byp   <= tdi;
      end
    end
  end

  // Instruction latch and output stage move on the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      instr  <= I_IDCODE;
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      if (st == S_RESET)       instr <= I_IDCODE;
      else if (st == S_IR_UPD) instr <= ir_sr;
      tdo    <= (st == S_IR_SH) ? ir_sr[0] : dr_bit;
      tdo_en <= (st == S_IR_SH) || (st == S_DR_SH);
    end
  end

  // USER1, BYPASS and unlisted codes fall through to the bypass stage.
  assign sel_id  = instr == I_IDCODE;
  assign sel_bsr = (instr == I_EXTEST) || (instr == I_SAMPLE) || (instr == I_INTEST);
  assign dr_bit  = sel_id ? id_sr[0] : (sel_bsr ? bsr_so : byp);

  assign bsr_capture = sel_bsr && (st == S_DR_CAP);
  assign bsr_shift   = sel_bsr && (st == S_DR_SH);
  assign bsr_update  = sel_bsr && (st == S_DR_UPD);
  assign bsr_extest  = (instr == I_EXTEST) || (instr == I_CLAMP);
  assign bsr_intest  = instr == I_INTEST;
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk (
  input logic       tck,
  input logic       trst_n,
  input logic [3:0] st,
  input logic [3:0] ir_sr,
  input logic [3:0] instr,
  input logic       tdo_en,
  input logic       bsr_capture,
  input logic       bsr_shift,
  input logic       bsr_update,
  input logic       bsr_extest,
  input logic       bsr_intest
);
  localparam logic [3:0] C_RESET = 4'd0;
  localparam logic [3:0] C_DR_SH = 4'd4;
  localparam logic [3:0] C_IR_CAP = 4'd10;
  localparam logic [3:0] C_IR_SH = 4'd11;
  localparam logic [3:0] C_IR_UPD = 4'd15;

  AST_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_IR_CAP) |=> (ir_sr == 4'b0001)); // R3
  AST_RESET_RELOAD: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_RESET) |=> (instr == 4'b0100)); // R4
  AST_INSTR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (st != C_IR_UPD && st != C_RESET) |-> $stable(instr)); // R4
  AST_CLAMP_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == 4'b0011) |-> (bsr_extest && !bsr_capture && !bsr_shift && !bsr_update)); // R7
  AST_STROBE_ONE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update})); // R8
  AST_MODE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
    !(bsr_extest && bsr_intest)); // R9
  AST_EN_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (st == C_DR_SH || st == C_IR_SH)); // R10
endmodule

bind scan_port scan_port_chk u_chk (
  .tck(tck), .trst_n(trst_n), .st(st), .ir_sr(ir_sr), .instr(instr),
  .tdo_en(tdo_en), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
  .bsr_update(bsr_update), .bsr_extest(bsr_extest), .bsr_intest(bsr_intest)
);

// File: tb/tb_scan_port.sv
module tb_scan_port;
  localparam int PERIOD = 20;
  localparam logic [3:0]  VER = 4'h3;
  localparam logic [15:0] PRT = 16'h7a5c;
  localparam logic [10:0] MKR = 11'h2b1;
  localparam logic [31:0] IDW = {VER, PRT, MKR, 1'b1};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
  logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, bsr_extest, bsr_intest;
  logic [3:0] instr;

  scan_port #(.VERSION(VER), .PART(PRT), .MAKER(MKR)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .instr(instr), .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .bsr_extest(bsr_extest), .bsr_intest(bsr_intest));

  always #(PERIOD/2) tck = ~tck;

  int checks = 0, errors = 0;
  int mst;
  logic [3:0] m_ir_sr, m_instr;
  logic [31:0] m_id;
  logic m_byp, m_tdo, m_tdo_en;
  logic [15:0] lfsr = 16'hace1;
  logic got[$];

  task automatic check_v(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nxt(int s, logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  function automatic logic sel_bsr(logic [3:0] i);
    return i == 4'b0000 || i == 4'b0001 || i == 4'b0010;
  endfunction

  task automatic model_reset();
    mst = 0; m_instr = 4'b0100; m_ir_sr = '0; m_id = '0;
    m_byp = 0; m_tdo = 0; m_tdo_en = 0;
  endtask

  task automatic compare();
    check_v("R10 tdo_en", tdo_en, m_tdo_en);
    if (m_tdo_en) check_v("R10 tdo", tdo, m_tdo);
    check_v("R4 instr", instr, m_instr);
    check_v("R8 capture", bsr_capture, sel_bsr(m_instr) && mst == 3);
    check_v("R8 shift", bsr_shift, sel_bsr(m_instr) && mst == 4);
    check_v("R8 update", bsr_update, sel_bsr(m_instr) && mst == 8);
    check_v("R9 extest", bsr_extest, m_instr == 4'b0000 || m_instr == 4'b0011);
    check_v("R9 intest", bsr_intest, m_instr == 4'b0010);
  endtask

  task automatic tick(logic t, logic d);
    tms = t; tdi = d;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bsr_so = lfsr[0];
    @(posedge tck);
    if (mst == 10) m_ir_sr = 4'b0001;
    else if (mst == 11) m_ir_sr = {d, m_ir_sr[3:1]};
    if (mst == 3) begin m_id = IDW; m_byp = 0; end
    else if (mst == 4) begin m_id = {d, m_id[31:1]}; m_byp = d; end
    mst = nxt(mst, t);
    @(negedge tck);
    if (mst == 0) m_instr = 4'b0100;
    else if (mst == 15) m_instr = m_ir_sr;
    m_tdo_en = (mst == 4) || (mst == 11);
    if (mst == 11) m_tdo = m_ir_sr[0];
    else if (m_instr == 4'b0100) m_tdo = m_id[0];
    else if (sel_bsr(m_instr)) m_tdo = bsr_so;
    else m_tdo = m_byp;
    #2;
    compare();
    if (tdo_en) got.push_back(tdo);
  endtask

  task automatic scan_ir(logic [3:0] code);
    tick(1, 0); tick(1, 0); tick(0, 0);
    got.delete();
    tick(0, 0);
    for (int i = 0; i < 3; i++) tick(0, code[i]);
    tick(1, code[3]);
    check_v("R3 ir capture bits", {got[3], got[2], got[1], got[0]}, 4'b0001);
    tick(1, 0); tick(0, 0);
    check_v("R4 instr after update", instr, code);
  endtask

  task automatic scan_dr(int n, logic [63:0] din);
    tick(1, 0); tick(0, 0);
    got.delete();
    tick(0, 0);
    for (int i = 0; i < n - 1; i++) tick(0, din[i]);
    tick(1, din[n-1]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic bypass_check(string tag);
    logic [7:0] pat = 8'b1011_0010;
    scan_dr(8, {56'd0, pat});
    check_v({tag, " first bit"}, got[0], 1'b0);
    for (int i = 1; i < 8; i++) check_v({tag, " delayed bit"}, got[i], pat[i-1]);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge tck); @(negedge tck); #2;
    check_v("R1 reset instr", instr, 4'b0100);
    check_v("R1 reset tdo_en", tdo_en, 1'b0);
    check_v("R1 reset strobes", {bsr_capture, bsr_shift, bsr_update}, 3'b000);
    compare();
    trst_n = 1;
    tick(0, 0);

    scan_dr(32, 64'h0);
    for (int i = 0; i < 32; i++) check_v("R5 id bit", got[i], IDW[i]);

    scan_ir(4'b1111); bypass_check("R6 bypass");
    scan_ir(4'b0110); bypass_check("R6 unlisted");
    scan_ir(4'b0101); bypass_check("R6 user1");

    scan_ir(4'b0011);
    check_v("R7 clamp extest", bsr_extest, 1'b1);
    bypass_check("R7 clamp path");

    scan_ir(4'b0000);
    scan_dr(12, 64'h5a3);
    check_v("R8 extest chain bits", got.size(), 12);
    tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(1, 0); tick(0, 0); tick(1, 0); tick(1, 0); tick(0, 0);
    scan_ir(4'b0001); scan_dr(6, 64'h2d);
    scan_ir(4'b0010);
    check_v("R9 intest mode", bsr_intest, 1'b1);
    scan_dr(6, 64'h15);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    tick(0, 0); tick(1, 0); tick(0, 1); tick(1, 1); tick(1, 0); tick(0, 0);

    scan_ir(4'b0000);
    tick(1, 0); tick(0, 0); tick(0, 0);
    check_v("R8 shift in scan", bsr_shift, 1'b1);
    for (int i = 0; i < 5; i++) tick(1, 0);
    check_v("R2 five ones instr", instr, 4'b0100);
    check_v("R2 five ones strobes", {bsr_capture, bsr_shift, bsr_update}, 3'b000);
    tick(0, 0);

    scan_ir(4'b0000);
    tick(1, 0); tick(0, 0); tick(0, 0);
    trst_n = 0;
    #1;
    check_v("R1 async tdo_en", tdo_en, 1'b0);
    check_v("R1 async instr", instr, 4'b0100);
    check_v("R1 async shift", bsr_shift, 1'b0);
    model_reset();
    @(negedge tck); #2;
    trst_n = 1;
    compare();
    tick(0, 0);
    scan_dr(32, 64'hffff_ffff);
    for (int i = 0; i < 32; i++) check_v("R5 id after trst", got[i], IDW[i]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule